// File: doc/BRIEF.md
# LIN Break Generating Serial Transmitter

This block is a serial transmitter for byte frames that can also place a LIN break on the line. A byte is handed over through a valid/ready write port into a single holding register. Each byte goes out as a start bit (low), eight data bits with the least significant bit first, and a stop bit (high). Every bit lasts one interval of an external bit-rate tick. When the LIN-mode enable is set, a one-cycle request makes the transmitter send a break instead of a data frame. The break is thirteen low bit times followed by exactly one high delimiter bit, after which the next frame may start at once.

A break request that arrives while a frame is on the line waits until that frame's stop bit has finished. When a break and a held byte are both waiting, the break goes first. A one-cycle done pulse marks the end of the delimiter bit. Outside LIN mode, break requests have no effect.

Top module: `lin_brk_tx`

## Requirements
- R1: After reset `tx` is 1, `busy` is 0, `wr_ready` is 1 and `brk_done` is 0. `tx` is 1 whenever `busy` is 0.
- R2: A data frame is sent as bit 0 = start (0), bits 1..8 = `wr_data[0]`..`wr_data[7]`, bit 9 = stop (1). Each bit holds for one tick interval, and `tx` changes only after a clock edge at which `bit_tick` is 1.
- R3: `wr_ready` is 1 exactly when no byte is held. A byte is taken on a clock edge with `wr_valid` and `wr_ready` both high, after which `wr_ready` is 0. A held byte starts at the tick that ends the current stop bit, with no idle gap.
- R4: A `brk_req` pulse while `lin_mode` is 1 makes `tx` low for exactly 13 consecutive tick intervals.
- R5: The 13 low intervals are followed by exactly one high interval, after which a pending frame starts immediately. `tx` is never low for more than 13 tick intervals in a row.
- R6: `brk_req` while `lin_mode` is 0 is ignored: `tx` stays 1 and `busy` stays 0. A pending break is discarded if `lin_mode` falls before it starts.
- R7: A break requested during a data frame starts at the tick that ends that frame's stop bit, and the frame completes unaltered.
- R8: If a break and a held byte are both pending when the transmitter becomes free, the break is sent first and the byte immediately after the delimiter.
- R9: `brk_done` is a single-cycle pulse in the cycle after the tick edge that ends the delimiter bit.
- R10: `busy` rises only after a tick edge. It is 1 from the start of a frame or break until the tick that ends it with nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit time from the baud generator |
| lin_mode | input | 1 | Enables break generation |
| wr_valid | input | 1 | Byte offered on `wr_data` |
| wr_data | input | 8 | Byte to send |
| wr_ready | output | 1 | Holding register is empty |
| brk_req | input | 1 | One-cycle request to send a break |
| tx | output | 1 | Serial line, idles high |
| busy | output | 1 | A frame, break or delimiter is on the line |
| brk_done | output | 1 | One-cycle pulse when the delimiter bit ends |

## Verification
A wrong bit counter or shift register shows on `tx` within one frame. It appears as a misplaced start or stop level, a data bit out of order, or a low run of the wrong length, and the first bad bit is visible one tick after it is driven. A stuck pending-break flag or holding flag shows as a break or byte that never starts, or one that starts twice. Such faults appear within one frame time as `tx` falling when it should stay high, or as `wr_ready` staying low. A wrong arbitration order shows as a start bit where a 13-bit low run was expected, in the very first interval after the transmitter becomes free.

// File: rtl/lin_brk_tx.sv
module lin_brk_tx #(
  parameter int DATA_W  = 8,
  parameter int BRK_LEN = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              lin_mode,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              brk_req,
  output logic              tx,
  output logic              busy,
  output logic              brk_done
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int MAXC    = (FRAME_W > BRK_LEN) ? FRAME_W : BRK_LEN;
  localparam int CNT_W   = $clog2(MAXC);

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_BRK, S_DELIM} st_t;

  st_t               st;
  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] hold_d;
  logic              hold_v, brk_pend, done_r;
  logic              free, go_brk, go_data;

  assign free    = bit_tick && (st == S_IDLE || st == S_DELIM ||
                   (st == S_DATA && cnt == CNT_W'(FRAME_W - 1)));
  assign go_brk  = free && brk_pend && lin_mode;
  assign go_data = free && !go_brk && hold_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sh       <= '1;
      cnt      <= '0;
      hold_d   <= '0;
      hold_v   <= 1'b0;
      brk_pend <= 1'b0;
      done_r   <= 1'b0;
    end else begin
      done_r   <= bit_tick && st == S_DELIM;
      brk_pend <= lin_mode && ((brk_pend && !go_brk) || brk_req);
      if (wr_valid && !hold_v) begin
        hold_v <= 1'b1;
        hold_d <= wr_data;
      end else if (go_data) begin
        hold_v <= 1'b0;
      end
      if (go_brk) begin
        st  <= S_BRK;
        cnt <= '0;
      end else if (go_data) begin
        st  <= S_DATA;
        cnt <= '0;
        sh  <= {1'b1, hold_d, 1'b0};
      end else if (free) begin
        st <= S_IDLE;
      end else if (bit_tick) begin
        case (st)
          S_DATA: begin
            sh  <= {1'b1, sh[FRAME_W-1:1]};
            cnt <= cnt + 1'b1;
          end
          S_BRK: begin
            if (cnt == CNT_W'(BRK_LEN - 1)) st <= S_DELIM;
            else cnt <= cnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign tx       = (st == S_DATA) ? sh[0] : (st != S_BRK);
  assign busy     = (st != S_IDLE);
  assign wr_ready = !hold_v;
  assign brk_done = done_r;
endmodule

// File: rtl/lin_brk_tx_chk.sv
module lin_brk_tx_chk #(
  parameter int BRK_LEN = 13
) (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic wr_valid,
  input logic wr_ready,
  input logic tx,
  input logic busy,
  input logic brk_done
);
  logic [7:0] low_ticks;

  always_ff @(posedge clk) begin
    if (!rst_n || tx) low_ticks <= '0;
    else if (bit_tick && low_ticks != 8'hff) low_ticks <= low_ticks + 1'b1;
  end

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> tx);
  // R2
  tx_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(tx) |-> $past(bit_tick));
  // R3
  hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_valid && wr_ready |=> !wr_ready);
  // R5
  low_run_chk: assert property (@(posedge clk) disable iff (!rst_n) low_ticks <= 8'(BRK_LEN));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) brk_done |=> !brk_done);
  // R9
  done_tick_chk: assert property (@(posedge clk) disable iff (!rst_n) brk_done |-> $past(bit_tick) && $past(tx));
  // R10
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(bit_tick));
endmodule

bind lin_brk_tx lin_brk_tx_chk #(.BRK_LEN(BRK_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .tx(tx), .busy(busy), .brk_done(brk_done)
);

// File: tb/sim_lin_brk_tx.sv
`timescale 1ns/1ps
module sim_lin_brk_tx;
  logic clk = 0, rst_n = 0, bit_tick = 0, lin_mode = 0, wr_valid = 0, brk_req = 0;
  logic [7:0] wr_data = '0;
  logic wr_ready, tx, busy, brk_done;
  int checks = 0, fails = 0;
  int tdiv = 0;
  bit finished = 0;

  lin_brk_tx u0 (.clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .lin_mode(lin_mode),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready), .brk_req(brk_req),
    .tx(tx), .busy(busy), .brk_done(brk_done));

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    bit_tick = (tdiv == 0);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick_edge();
    @(posedge clk);
    while (!bit_tick) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk); wr_valid = 1; wr_data = d;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic pulse_brk();
    @(negedge clk); brk_req = 1;
    @(negedge clk); brk_req = 0;
  endtask

  task automatic get_bits(input int n, output logic [9:0] f);
    f = '0;
    for (int i = 0; i < n; i++) begin
      tick_edge();
      f[i] = tx;
    end
  endtask

  task automatic get_brk(input string req);
    int lows = 0;
    for (int i = 0; i < 13; i++) begin
      tick_edge();
      if (tx == 0) lows++;
    end
    check(lows == 13, req, lows, 13);
    tick_edge();
    check(tx == 1, "R5 delimiter high", tx, 1);
  endtask

  initial begin
    logic [9:0] f;
    logic [8:0] rest;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(tx == 1 && busy == 0 && wr_ready == 1 && brk_done == 0, "R1 reset",
          {tx, busy, wr_ready, brk_done}, 4'b1010);

    // R2 sweep over all byte values, both lin_mode settings
    for (int d = 0; d < 256; d++) begin
      lin_mode = d[0];
      write_byte(8'(d));
      get_bits(10, f);
      check(f == {1'b1, 8'(d), 1'b0}, "R2 frame", f, {1'b1, 8'(d), 1'b0});
    end
    tick_edge();
    check(tx == 1 && busy == 0, "R10 idle after frame", {tx, busy}, 2'b10);

    // R3 back-to-back frames through the holding register
    write_byte(8'hA5);
    tick_edge();
    check(tx == 0, "R3 start bit A", tx, 0);
    write_byte(8'h3C);
    check(wr_ready == 0, "R3 hold full", wr_ready, 0);
    get_bits(9, f);
    rest = f[8:0];
    check(rest == {1'b1, 8'hA5}, "R3 rest of A", rest, {1'b1, 8'hA5});
    get_bits(10, f);
    check(f == {1'b1, 8'h3C, 1'b0}, "R3 B without gap", f, {1'b1, 8'h3C, 1'b0});
    tick_edge();

    // R4 R5 R9 break in LIN mode
    lin_mode = 1;
    tick_edge();
    pulse_brk();
    get_brk("R4 break low run");
    check(brk_done == 0, "R9 no early done", brk_done, 0);
    tick_edge();
    check(brk_done == 1 && tx == 1 && busy == 0, "R9 done pulse", {brk_done, tx, busy}, 3'b110);
    @(negedge clk);
    check(brk_done == 0, "R9 single cycle", brk_done, 0);

    // R6 ignored outside LIN mode
    lin_mode = 0;
    tick_edge();
    pulse_brk();
    for (int i = 0; i < 3; i++) begin
      tick_edge();
      check(tx == 1 && busy == 0, "R6 ignored", {tx, busy}, 2'b10);
    end
    // R6 pending break dropped when lin_mode falls
    lin_mode = 1;
    tick_edge();
    pulse_brk();
    lin_mode = 0;
    tick_edge();
    lin_mode = 1;
    for (int i = 0; i < 2; i++) begin
      tick_edge();
      check(tx == 1 && busy == 0, "R6 dropped", {tx, busy}, 2'b10);
    end

    // R7 break during a frame waits for the stop bit
    write_byte(8'h81);
    get_bits(3, f);
    pulse_brk();
    begin
      logic [9:0] g;
      get_bits(7, g);
      f[9:3] = g[6:0];
    end
    check(f == {1'b1, 8'h81, 1'b0}, "R7 frame intact", f, {1'b1, 8'h81, 1'b0});
    get_brk("R7 break after stop");
    tick_edge();
    check(brk_done == 1, "R7 done", brk_done, 1);

    // R8 break ahead of a held byte
    tick_edge();
    @(negedge clk); wr_valid = 1; wr_data = 8'h5A; brk_req = 1;
    @(negedge clk); wr_valid = 0; brk_req = 0;
    get_brk("R8 break first");
    get_bits(10, f);
    check(f == {1'b1, 8'h5A, 1'b0}, "R8 byte after delimiter", f, {1'b1, 8'h5A, 1'b0});
    tick_edge();
    check(busy == 0 && tx == 1, "R10 idle at end", {busy, tx}, 2'b01 << 0 | 2'b00);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule